// File: doc/BRIEF.md
# Recirculating Operand Ring Source

This block supplies an adder under test with a never-ending stream of operand sets, without a memory or an address counter. Every operand bit lives in its own small ring of nine single-bit pipeline stages: one ring per bit of operand A, one per bit of operand B and one for the carry-in. All rings share one occupancy pattern, so a "token" in a stage stands for the same bit position of one whole operand set. A stage holds either a token or a bubble. A token moves forward only into a bubble, and the last stage feeds back into the first.

Software first issues a load command that carries a set count from 1 to 7. It then streams that many 129-bit words in through a valid/ready load port. Once the last word is taken, the block switches to run mode. From then on the set that has reached the last stage is offered on a valid/ready output stream. When the consumer takes it, that token re-enters the head of the ring, behind the newest set. The sets therefore repeat in load order for as long as the block runs. Back-pressure works as follows. When `out_ready` is low, the offered set stays on the port and nothing is lost. The load port gives `load_ready` only while a load is still open and the ring head holds a bubble.

Top module: `operand_ring_source`

## Requirements
- R1: After reset every ring is empty: `out_valid`, `load_ready` and `load_err` are 0.
- R2: A load command (`load_start` high with `load_count` in 1..7) empties all rings and opens a load. The load then accepts exactly that many words, one per cycle in which `load_valid` and `load_ready` are both high. After the last word, `load_ready` returns to 0.
- R3: A load command with `load_count` of 0 or 8..15 is rejected. `load_err` goes to 1 in the next cycle. The ring contents and the output sequence stay as they were. The next accepted load command clears `load_err`.
- R4: While a load is open, `load_start` is ignored: the set count of the open load does not change.
- R5: `out_valid` stays 0 while a load is open, and also before the first load.
- R6: In run mode the sets come out in load order. After set N-1, set 0 comes next, and this repeats without end.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_a`, `out_b`, `out_cin` hold their values. A set leaves the ring only on a cycle where `out_valid` and `out_ready` are both 1, and no set is skipped.
- R8: A ring never holds more than seven tokens, so at least two bubbles remain. In run mode the token count does not change.
- R9: Word layout: `load_data[63:0]` is operand A, `load_data[127:64]` is operand B and `load_data[128]` is the carry-in. These appear on `out_a`, `out_b` and `out_cin`.
- R10: An accepted load command issued in run mode replaces the old pattern. Only the newly loaded sets come out after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Load command strobe |
| load_count | input | 4 | Number of sets to load with the command |
| load_err | output | 1 | Last load command was rejected |
| load_valid | input | 1 | Load word valid |
| load_ready | output | 1 | Load word can be taken |
| load_data | input | 129 | Load word {cin, B, A} |
| out_valid | output | 1 | Operand set offered |
| out_ready | input | 1 | Consumer takes the set |
| out_a | output | 64 | Operand A |
| out_b | output | 64 | Operand B |
| out_cin | output | 1 | Carry-in |

## Verification
Random words are loaded with set counts of 1, 3 and 7. They are consumed with a randomly toggled `out_ready`. This separates a correct recirculation order from a ring that drops or duplicates tokens when the consumer stalls. A count of 1 exercises the shortest wrap, and a count of 7 fills the ring to its two-bubble limit. A directed all-ones/all-zeros set shows that the fields keep their positions. Rejected counts 0 and 9, issued in run mode, must leave the sequence exactly where it was. A stray command issued in the middle of a load must not change the period that is later observed on the output.

// File: rtl/ring_src_pkg.sv
package ring_src_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ring_occupancy.sv
module ring_occupancy #(
  parameter int STAGES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inj,
  input  logic              allow_wrap,
  input  logic              run,
  output logic [STAGES-2:0] move,
  output logic              wrap,
  output logic              head_free,
  output logic              tail_full
);
  localparam int MAX_TOK = STAGES - 2;

  logic [STAGES-1:0] occ, occ_nx;

  assign head_free = !occ[0];
  assign tail_full = occ[STAGES-1];
  assign wrap      = occ[STAGES-1] && !occ[0] && allow_wrap;

  // a token advances only into a stage that was empty at the start of the cycle
  for (genvar i = 0; i < STAGES-1; i++) begin : g_move
    assign move[i] = occ[i] && !occ[i+1];
  end

  always_comb begin
    occ_nx[0] = (occ[0] && !move[0]) || inj || wrap;
    for (int i = 1; i < STAGES-1; i++)
      occ_nx[i] = (occ[i] && !move[i]) || move[i-1];
    occ_nx[STAGES-1] = (occ[STAGES-1] && !wrap) || move[STAGES-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     occ <= '0;
    else if (clear) occ <= '0;
    else            occ <= occ_nx;
  end

  // R8: two bubbles always remain
  a_r8_two_bubbles: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) <= MAX_TOK);

  // R8: recirculation neither creates nor destroys tokens
  a_r8_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear) |=> ($countones(occ) == $countones($past(occ))));
endmodule

// File: rtl/ring_bit_lane.sv
module ring_bit_lane #(
  parameter int STAGES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-2:0] move,
  input  logic              inj,
  input  logic              wrap,
  input  logic              load_bit,
  output logic              tap
);
  logic [STAGES-1:0] bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else begin
      if (inj)       bits[0] <= load_bit;
      else if (wrap) bits[0] <= bits[STAGES-1];
      for (int i = 1; i < STAGES; i++)
        if (move[i-1]) bits[i] <= bits[i-1];
    end
  end

  assign tap = bits[STAGES-1];
endmodule

// File: rtl/load_sequencer.sv
module load_sequencer
  import ring_src_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int MAX_SETS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic [CNT_W-1:0] load_count,
  input  logic             load_valid,
  input  logic             head_free,
  output logic             load_ready,
  output logic             inj,
  output logic             clear,
  output logic             run,
  output logic             load_err
);
  seq_state_e       state;
  logic [CNT_W-1:0] remain;
  logic             cmd_ok, cmd_bad, open_cmd;

  assign open_cmd   = load_start && (state != SEQ_LOAD);
  assign cmd_ok     = open_cmd && (load_count != '0) && (load_count <= CNT_W'(MAX_SETS));
  assign cmd_bad    = open_cmd && !cmd_ok;
  assign clear      = cmd_ok;
  assign load_ready = (state == SEQ_LOAD) && head_free;
  assign inj        = load_ready && load_valid;
  assign run        = (state == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      remain   <= '0;
      load_err <= 1'b0;
    end else begin
      if (cmd_ok) begin
        state    <= SEQ_LOAD;
        remain   <= load_count;
        load_err <= 1'b0;
      end else if (cmd_bad) begin
        load_err <= 1'b1;
      end else if (inj) begin
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) state <= SEQ_RUN;
      end
    end
  end

  // R3: a bad count raises the error flag
  a_r3_bad_count_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> load_err);

  // R2: a load never takes more words than it announced
  a_r2_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    inj |-> (remain != '0));

  // R4: a command during an open load leaves the count alone
  a_r4_ignore_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_LOAD && load_start && !inj) |=> $stable(remain));
endmodule

// File: rtl/operand_ring_source.sv
module operand_ring_source #(
  parameter int OP_W     = 64,
  parameter int STAGES   = 9,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic [CNT_W-1:0]  load_count,
  output logic              load_err,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [2*OP_W:0]   load_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   out_a,
  output logic [OP_W-1:0]   out_b,
  output logic              out_cin
);
  localparam int WORD_W   = 2*OP_W + 1;
  localparam int MAX_SETS = STAGES - 2;

  logic              inj, clear, run, wrap, head_free, tail_full;
  logic [STAGES-2:0] move;
  logic [WORD_W-1:0] taps;

  load_sequencer #(.CNT_W(CNT_W), .MAX_SETS(MAX_SETS)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_count(load_count),
    .load_valid(load_valid), .head_free(head_free), .load_ready(load_ready),
    .inj(inj), .clear(clear), .run(run), .load_err(load_err)
  );

  ring_occupancy #(.STAGES(STAGES)) u_occ (
    .clk(clk), .rst_n(rst_n), .clear(clear), .inj(inj),
    .allow_wrap(run && out_ready), .run(run), .move(move), .wrap(wrap),
    .head_free(head_free), .tail_full(tail_full)
  );

  for (genvar b = 0; b < WORD_W; b++) begin : g_lane
    ring_bit_lane #(.STAGES(STAGES)) u_lane (
      .clk(clk), .rst_n(rst_n), .move(move), .inj(inj), .wrap(wrap),
      .load_bit(load_data[b]), .tap(taps[b])
    );
  end

  assign out_valid = run && tail_full && head_free;
  assign out_a     = taps[OP_W-1:0];
  assign out_b     = taps[2*OP_W-1:OP_W];
  assign out_cin   = taps[2*OP_W];

  // R7: an offered set waits for the consumer unchanged
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load_start) |=> (out_valid && $stable(taps)));

  // R5: no output while words are still being taken
  a_r5_quiet_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |-> !out_valid);

  // R7: a set leaves the ring exactly on a handshake
  a_r7_wrap_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (out_valid && out_ready));
endmodule

// File: tb/test_operand_ring_source.sv
`timescale 1ns/1ps
module test_operand_ring_source;
  localparam int OP_W = 64;
  localparam int W    = 2*OP_W + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_start = 1'b0;
  logic [3:0]    load_count = '0;
  logic          load_err;
  logic          load_valid = 1'b0;
  logic          load_ready;
  logic [W-1:0]  load_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OP_W-1:0] out_a, out_b;
  logic          out_cin;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_set [7];
  int exp_n = 0;
  int exp_ptr = 0;

  always #4 clk = ~clk;

  operand_ring_source i_operand_ring_source (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_count(load_count),
    .load_err(load_err), .load_valid(load_valid), .load_ready(load_ready),
    .load_data(load_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_b(out_b), .out_cin(out_cin)
  );

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] w;
    w = {$urandom, $urandom, $urandom, $urandom, $urandom};
    return w;
  endfunction

  function automatic logic [W-1:0] out_word();
    return {out_cin, out_b, out_a};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] n);
    @(negedge clk);
    load_start = 1'b1;
    load_count = n;
    @(negedge clk);
    load_start = 1'b0;
  endtask

  task automatic push_word(input logic [W-1:0] w);
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = w;
    forever begin
      if (load_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    load_valid = 1'b0;
    check("R5 out_valid low during load", W'(out_valid), W'(0));
  endtask

  task automatic load_sets(input int n, input logic [W-1:0] first);
    cmd(4'(n));
    for (int k = 0; k < n; k++) begin
      exp_set[k] = (k == 0) ? first : rand_word();
      push_word(exp_set[k]);
    end
    exp_n = n;
    exp_ptr = 0;
    check("R2 load_ready low after last word", W'(load_ready), W'(0));
  endtask

  // consume k sets with random ready; check order, fields and stall hold
  task automatic consume(input int k, input int ready_pct);
    int got = 0;
    logic held = 1'b0;
    logic [W-1:0] held_w = '0;
    while (got < k) begin
      @(negedge clk);
      if (held) begin
        check("R7 valid held during stall", W'(out_valid), W'(1));
        check("R7 data held during stall", out_word(), held_w);
      end
      out_ready = (($urandom % 100) < ready_pct);
      held = 1'b0;
      if (out_valid && out_ready) begin
        check("R6 set order", out_word(), exp_set[exp_ptr]);
        check("R9 carry field", W'(out_cin), W'(exp_set[exp_ptr][W-1]));
        exp_ptr = (exp_ptr + 1) % exp_n;
        got++;
      end else if (out_valid) begin
        held = 1'b1;
        held_w = out_word();
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", W'(out_valid), W'(0));
    check("R1 load_ready reset", W'(load_ready), W'(0));
    check("R1 load_err reset", W'(load_err), W'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 out_valid before load", W'(out_valid), W'(0));

    // R9 directed field layout: A all ones, B zero, cin one
    load_sets(3, {1'b1, {OP_W{1'b0}}, {OP_W{1'b1}}});
    consume(10, 60);

    // R3 rejected counts keep the sequence
    cmd(4'd0);
    check("R3 load_err on count 0", W'(load_err), W'(1));
    consume(4, 50);
    cmd(4'd9);
    check("R3 load_err on count 9", W'(load_err), W'(1));
    consume(5, 70);

    // R10 replace pattern with 7 sets; R8 full ring
    load_sets(7, rand_word());
    check("R3 load_err cleared by good load", W'(load_err), W'(0));
    consume(20, 40);

    // R6 shortest wrap
    load_sets(1, rand_word());
    consume(6, 100);

    // R4 command inside an open load is ignored
    cmd(4'd3);
    exp_set[0] = rand_word(); push_word(exp_set[0]);
    cmd(4'd5);
    exp_set[1] = rand_word(); push_word(exp_set[1]);
    exp_set[2] = rand_word(); push_word(exp_set[2]);
    exp_n = 3; exp_ptr = 0;
    check("R4 load closed after original count", W'(load_ready), W'(0));
    consume(9, 80);

    // long random run
    load_sets(5, rand_word());
    consume(60, 50);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule